// File: doc/BRIEF.md
# Multi-mode fixed-point requantizer

The requantizer narrows a stream of fixed-point samples by removing a fixed number of least significant bits, `DROP`. Each sample arrives with a valid strobe, a flag that marks it as two's-complement or unsigned, and a rounding-mode code. The block rounds the sample to the nearest output step. Only an exact half step (a tie) takes the policy chosen by the mode code: away from zero, to the even neighbour, or alternating up and down. When a rounded result no longer fits in the narrower word, the block either saturates to the largest positive code or wraps, depending on a build-time parameter.

The alternating policy keeps a one-bit state machine with two states. `TIE_UP` rounds the next tie upward and is the state after reset. `TIE_DOWN` rounds the next tie downward. The transition `TIE_UP -> TIE_DOWN` or `TIE_DOWN -> TIE_UP` is taken only on a valid tie sample in alternating mode. Any other sample makes the machine stay in its current state. The result is registered once, so a sample's output appears one clock after it is presented.

Top module: `rq_requant`

## Requirements
- R1: The output width is `IN_W - DROP`. With `DROP = 0` the output equals the input for every mode and sign setting.
- R2: When the dropped fraction is below one half, the result is the floor of the scaled value. When the fraction is above one half, the result is the floor plus one. This holds in every mode.
- R3: For unsigned samples (`in_signed = 0`) in mode `2'b00` (away), a tie rounds up, so 2.5 gives 3.
- R4: For signed samples in mode `2'b00`, a non-negative tie rounds up and a negative tie rounds down, so +2.5 gives 3 and -2.5 gives -3. Mode code `2'b11` behaves exactly like `2'b00`.
- R5: In mode `2'b01` (even), a tie rounds to the even neighbour: 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R6: In mode `2'b10` (alternate), the first tie after reset rounds up, the next tie rounds down, and so on. Non-tie samples round to nearest.
- R7: The alternate state changes only on a sample that is valid, is a tie and uses mode `2'b10`. Ties in other modes, invalid cycles and non-tie samples leave it unchanged.
- R8: With `CLIP_EN = 1`, a result above the largest output code gives the maximum positive code: `0x7F..` for signed samples and all ones for unsigned samples. Negative samples never overflow.
- R9: With `CLIP_EN = 0`, an overflowing result wraps modulo `2**(IN_W-DROP)`.
- R10: `out_valid` is `in_valid` delayed by one clock. `out_data` changes only one clock after a valid input and otherwise holds its value.
- R11: A synchronous reset (`rst` high) clears `out_valid` and `out_data` to 0 and returns the alternate state to `TIE_UP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Input sample |
| in_signed | input | 1 | 1 = two's-complement sample, 0 = unsigned |
| in_mode | input | 2 | Tie policy: 00 away, 01 even, 10 alternate, 11 away |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_data | output | IN_W-DROP | Rounded, clipped or wrapped result |

## Verification
The only hidden state is the alternate tie bit. If it is wrong, the first alternating-mode tie after the fault returns a result that is off by exactly one, and that result appears one clock after the sample. Tie samples in other modes, and invalid cycles, are placed between alternating ties so that a state machine that advances when it should not is exposed on the next tie. A random stream with ties forced in is compared against an integer floor-division model that tracks its own tie bit.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic [1:0] {
        RND_AWAY  = 2'b00,
        RND_EVEN  = 2'b01,
        RND_ALT   = 2'b10,
        RND_AWAY2 = 2'b11
    } rnd_mode_e;

    typedef enum logic {
        TIE_UP   = 1'b0,
        TIE_DOWN = 1'b1
    } tie_state_e;
endpackage

// File: rtl/rq_tie_fsm.sv
module rq_tie_fsm
    import rq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic next_up
);
    tie_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            TIE_UP:   if (advance) state_nxt = TIE_DOWN;
            TIE_DOWN: if (advance) state_nxt = TIE_UP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TIE_UP;
        else     state <= state_nxt;
    end

    always_comb begin
        next_up = (state == TIE_UP);
    end

    // R7: without a qualifying tie the state machine stays in its current state
    p_tie_hold_r7: assert property (@(posedge clk) disable iff (rst || $past(rst))
        !$past(advance) |-> $stable(state));
    // R6: a qualifying tie always changes the state
    p_tie_flip_r6: assert property (@(posedge clk) disable iff (rst || $past(rst))
        $past(advance) |-> !$stable(state));
endmodule

// File: rtl/rq_round_core.sv
module rq_round_core
    import rq_pkg::*;
#(
    parameter int IN_W = 12,
    parameter int DROP = 4,
    localparam int OUT_W = IN_W - DROP
) (
    input  logic [IN_W-1:0]  din,
    input  logic             is_signed,
    input  rnd_mode_e        mode,
    input  logic             alt_up,
    output logic [OUT_W-1:0] rounded,
    output logic             ovf,
    output logic             tie
);
    generate
        if (DROP == 0) begin : g_pass
            always_comb begin
                rounded = din;
                ovf     = 1'b0;
                tie     = 1'b0;
            end
        end else begin : g_round
            localparam logic [DROP-1:0] HALF = DROP'(1) << (DROP - 1);
            logic [OUT_W-1:0] trunc;
            logic [DROP-1:0]  frac;
            logic [OUT_W-1:0] max_code;
            logic             tie_dir_up;
            logic             inc;

            always_comb begin
                trunc = din[IN_W-1:DROP];
                frac  = din[DROP-1:0];
                tie   = (frac == HALF);
                unique case (mode)
                    RND_EVEN: tie_dir_up = trunc[0];
                    RND_ALT:  tie_dir_up = alt_up;
                    default:  tie_dir_up = !(is_signed && din[IN_W-1]);
                endcase
                inc      = (frac > HALF) || (tie && tie_dir_up);
                max_code = is_signed ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
                ovf      = inc && (trunc == max_code);
                rounded  = trunc + OUT_W'(inc);
            end
        end
    endgenerate
endmodule

// File: rtl/rq_requant.sv
module rq_requant
    import rq_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int DROP    = 4,
    parameter bit CLIP_EN = 1'b1,
    localparam int OUT_W  = IN_W - DROP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_signed,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    rnd_mode_e        mode;
    logic             alt_up;
    logic             tie;
    logic             ovf;
    logic [OUT_W-1:0] rounded;
    logic [OUT_W-1:0] sat_code;
    logic [OUT_W-1:0] result;

    always_comb mode = rnd_mode_e'(in_mode);

    rq_tie_fsm u_tie (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid && tie && (mode == RND_ALT)),
        .next_up (alt_up)
    );

    rq_round_core #(.IN_W(IN_W), .DROP(DROP)) u_core (
        .din       (in_data),
        .is_signed (in_signed),
        .mode      (mode),
        .alt_up    (alt_up),
        .rounded   (rounded),
        .ovf       (ovf),
        .tie       (tie)
    );

    always_comb begin
        sat_code = in_signed ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
        result   = (CLIP_EN && ovf) ? sat_code : rounded;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= result;
        end
    end

    // R10: one-cycle valid latency
    p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst || $past(rst))
        out_valid == $past(in_valid));
    // R10: data holds on cycles without input
    p_data_hold_r10: assert property (@(posedge clk) disable iff (rst || $past(rst))
        !$past(in_valid) |-> $stable(out_data));
    // R8: overflow with clipping gives the saturation code
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst || $past(rst))
        (CLIP_EN && out_valid && $past(ovf)) |->
            out_data == ($past(in_signed) ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}}));
    // R5: a non-overflowing tie in even mode gives an even result
    p_even_tie_r5: assert property (@(posedge clk) disable iff (rst || $past(rst))
        (out_valid && $past(mode == RND_EVEN && tie && !ovf)) |-> !out_data[0]);
endmodule

// File: tb/sim_rq_requant.sv
module sim_rq_requant;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_signed = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic        out_valid, w_valid, p_valid;
    logic [7:0]  out_data, w_data, p_data;
    int checks = 0;
    int errors = 0;
    bit alt_up_m = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rq_requant u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_signed(in_signed), .in_mode(in_mode), .out_valid(out_valid), .out_data(out_data));
    rq_requant #(.CLIP_EN(1'b0)) u_wrap (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .in_signed(in_signed), .in_mode(in_mode),
        .out_valid(w_valid), .out_data(w_data));
    rq_requant #(.IN_W(8), .DROP(0)) u_pass (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data[7:0]), .in_signed(in_signed), .in_mode(in_mode),
        .out_valid(p_valid), .out_data(p_data));

    // fields: [26:23] requirement, [22] signed, [21:20] mode, [19:8] input, [7:0] expected
    localparam logic [26:0] VEC [NVEC] = '{
        {4'd2,  1'b0, 2'd0, 12'h025, 8'h02},  // R2 below half
        {4'd3,  1'b0, 2'd0, 12'h028, 8'h03},  // R3 unsigned tie up
        {4'd2,  1'b0, 2'd0, 12'h029, 8'h03},  // R2 above half
        {4'd2,  1'b0, 2'd0, 12'h027, 8'h02},  // R2
        {4'd5,  1'b0, 2'd1, 12'h028, 8'h02},  // R5 2.5 -> 2
        {4'd5,  1'b0, 2'd1, 12'h038, 8'h04},  // R5 3.5 -> 4
        {4'd4,  1'b1, 2'd0, 12'h028, 8'h03},  // R4 +2.5 -> 3
        {4'd4,  1'b1, 2'd0, 12'hFD8, 8'hFD},  // R4 -2.5 -> -3
        {4'd5,  1'b1, 2'd1, 12'hFD8, 8'hFE},  // R5 -2.5 -> -2
        {4'd5,  1'b1, 2'd1, 12'hFC8, 8'hFC},  // R5 -3.5 -> -4
        {4'd4,  1'b1, 2'd0, 12'hFC8, 8'hFC},  // R4 -3.5 -> -4
        {4'd2,  1'b1, 2'd0, 12'hFD9, 8'hFE},  // R2 negative above half
        {4'd8,  1'b1, 2'd0, 12'h7F8, 8'h7F},  // R8 signed clip
        {4'd8,  1'b1, 2'd0, 12'h7FF, 8'h7F},  // R8 signed clip at max
        {4'd2,  1'b1, 2'd0, 12'h7F7, 8'h7F},  // R2 just below clip
        {4'd8,  1'b0, 2'd0, 12'hFF8, 8'hFF},  // R8 unsigned clip
        {4'd8,  1'b1, 2'd0, 12'h800, 8'h80},  // R8 most negative
        {4'd8,  1'b1, 2'd0, 12'h808, 8'h80},  // R8 negative tie never overflows
        {4'd8,  1'b0, 2'd1, 12'hFF8, 8'hFF},  // R8 even overflow clipped
        {4'd4,  1'b0, 2'd3, 12'h028, 8'h03}   // R4 code 11 acts as away
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic [1:0] m, input logic [11:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_signed = s; in_mode = m; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        alt_up_m = 1'b1;
    endtask

    function automatic logic [7:0] model(input logic s, input logic [1:0] m,
                                         input logic [11:0] d, input bit aup);
        int v, fl, rem, r, mx;
        bit up;
        v   = s ? int'($signed(d)) : int'(d);
        fl  = (v >= 0) ? v / 16 : -((-v + 15) / 16);
        rem = v - fl * 16;
        if (m == 2'd1)      up = (fl & 1) != 0;
        else if (m == 2'd2) up = aup;
        else                up = (v >= 0);
        r  = fl + (((rem > 8) || (rem == 8 && up)) ? 1 : 0);
        mx = s ? 127 : 255;
        if (r > mx) r = mx;
        return r[7:0];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        check(11, {7'd0, out_valid}, 8'h00);   // R11 reset valid
        check(11, out_data, 8'h00);            // R11 reset data

        foreach (VEC[i]) begin
            drive(VEC[i][22], VEC[i][21:20], VEC[i][19:8]);
            check(int'(VEC[i][26:23]), out_data, VEC[i][7:0]);
        end

        // R10 latency and hold
        @(negedge clk);
        in_valid = 1'b1; in_signed = 1'b0; in_mode = 2'd0; in_data = 12'h051;
        check(10, {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        in_valid = 1'b0; in_data = 12'h0A0;
        check(10, {7'd0, out_valid}, 8'h01);
        check(10, out_data, 8'h05);
        @(negedge clk);
        check(10, {7'd0, out_valid}, 8'h00);
        check(10, out_data, 8'h05);

        // R6 / R7 alternate tie sequence
        do_reset();
        drive(1'b0, 2'd2, 12'h028); check(6, out_data, 8'h03);
        drive(1'b0, 2'd2, 12'h028); check(6, out_data, 8'h02);
        drive(1'b0, 2'd2, 12'h029); check(6, out_data, 8'h03);
        drive(1'b0, 2'd2, 12'h028); check(7, out_data, 8'h03);  // R7 non-tie kept state
        drive(1'b0, 2'd0, 12'h038); check(3, out_data, 8'h04);
        drive(1'b0, 2'd2, 12'h028); check(7, out_data, 8'h02);  // R7 away-mode tie kept state
        @(negedge clk);
        in_valid = 1'b0; in_mode = 2'd2; in_data = 12'h048;
        @(negedge clk);
        check(10, out_data, 8'h02);                              // R10 invalid ignored
        drive(1'b0, 2'd2, 12'h028); check(7, out_data, 8'h03);  // R7 invalid tie kept state
        drive(1'b1, 2'd2, 12'hFD8); check(6, out_data, 8'hFD);  // R6 signed tie down
        drive(1'b1, 2'd2, 12'hFD8); check(6, out_data, 8'hFE);  // R6 signed tie up

        // R11 reset restores round-up-first
        drive(1'b0, 2'd2, 12'h028);
        do_reset();
        drive(1'b0, 2'd2, 12'h028); check(11, out_data, 8'h03);

        // R9 wrap instance, R1 pass-through instance
        drive(1'b1, 2'd0, 12'h7F8); check(9, w_data, 8'h80);
        drive(1'b0, 2'd0, 12'hFF8); check(9, w_data, 8'h00);
        for (int m = 0; m < 4; m++) begin
            drive(m[0], m[1:0], 12'h0A5); check(1, p_data, 8'hA5);   // R1
        end

        // R2 random stream with forced ties against the model
        do_reset();
        for (int k = 0; k < 400; k++) begin
            logic [11:0] d;
            logic [1:0]  m;
            logic        s;
            logic [7:0]  e;
            d = 12'($urandom);
            m = 2'($urandom);
            s = 1'($urandom);
            if (k % 3 == 0) d[3:0] = 4'h8;
            if (k % 17 == 0) d = s ? 12'h7F8 : 12'hFF8;
            if (k % 19 == 0) d = 12'h808;
            e = model(s, m, d, alt_up_m);
            drive(s, m, d);
            check(2, out_data, e);
            if (m == 2'd2 && d[3:0] == 4'h8) alt_up_m = !alt_up_m;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule